// File: doc/BRIEF.md
# Cluster Core Rendezvous Register Block

This block lets the cores of one cluster meet at numbered synchronization points through ordinary register reads and writes. Every rendezvous point owns a group of four consecutive 32-bit words. One word reports whether the whole cluster has arrived. Each of the other words is a flag owned by one core. A core first waits until its flag reads idle (0). It then writes 1 to report arrival and polls the status word until that word reads nonzero. Once it has seen the release, it writes 2 to report that it has gone through.

The status stays set while some cores have gone through and others have not yet noticed the release, so a slow core cannot miss it. When every core of a rendezvous point holds 2, the block clears all of that point's flags and its status in a single cycle, which makes the point ready for its next use. The number of cores and the number of rendezvous points are parameters. The bus is word-addressed and takes one access per cycle. Read data returns one cycle after the request.

Top module: `mbar_unit`

## Requirements
- R1: After reset every flag word and every status word reads 0.
- R2: Rendezvous point b occupies word addresses 4*b to 4*b+3. Word 4*b is the status and word 4*b+1+c is the flag of core c. A read request returns `rd_valid`=1 with its data in the following cycle, and the data reflects the state before any effect of that same cycle.
- R3: Writing 1 to a flag word sets it to arrived (reads 1). Writing 2 sets it to passed (reads 2).
- R4: A write to a flag word with any 32-bit value other than 1 or 2 (including 0, 3 and 0x101) leaves the flag unchanged.
- R5: The status word reads 1 from the cycle after the write that leaves every core's flag at 1 or 2, and reads 0 while any flag is 0.
- R6: While a mix of arrived and passed flags is held, the status stays 1.
- R7: In the cycle after every flag of a point holds 2, all its flags and its status read 0. A flag write to that point in that same cycle is dropped.
- R8: Writes to a status word have no effect.
- R9: Words of a point beyond the last core's flag read 0, and writes to them have no effect.
- R10: Addresses at or beyond 4*NUM_BARRIERS read 0, and writes to them change no state.
- R11: Rendezvous points are independent: activity on one never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | DATA_W | Read data |

## Verification
Directed sequences step a point through the full idle, arrive, release, pass and re-arm cycle. Reads at each step separate the status timing from the flag timing and show whether the re-arm happens only after the last pass. Illegal values, writes to status and spare words, and out-of-range addresses are sent next to live flags: a change to those flags would expose decode aliasing or a missing value filter. Seeded random traffic then mixes arrivals, passes and junk writes over all points and out-of-range words. This finds interactions between points and writes that land in the re-arm cycle.

// File: rtl/mbar_pkg.sv
package mbar_pkg;

    // Per-core handshake value held in each flag word
    typedef enum logic [1:0] {
        FLAG_IDLE    = 2'd0,
        FLAG_ARRIVED = 2'd1,
        FLAG_PASSED  = 2'd2
    } flag_e;

    // Each rendezvous point spans this many words (address stride)
    localparam int unsigned WORDS_PER_POINT = 4;
    localparam int unsigned WORD_SEL_W      = 2;

endpackage

// File: rtl/mbar_decode.sv
module mbar_decode #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned NUM_BARRIERS = 4,
    parameter int unsigned NUM_CORES    = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic                    in_range,
    output logic [NUM_BARRIERS-1:0] bar_sel,
    output logic                    is_status,
    output logic [NUM_CORES-1:0]    core_sel
);
    import mbar_pkg::*;

    localparam int unsigned POINT_W = ADDR_W - WORD_SEL_W;

    logic [POINT_W-1:0]    point_idx;
    logic [WORD_SEL_W-1:0] word_idx;

    assign point_idx = addr[ADDR_W-1:WORD_SEL_W];
    assign word_idx  = addr[WORD_SEL_W-1:0];

    // one-hot select of the addressed rendezvous point
    for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_bar
        assign bar_sel[b] = (point_idx == POINT_W'(b));
    end

    // one-hot select of the addressed core flag within a point
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign core_sel[c] = (word_idx == WORD_SEL_W'(c + 1));
    end

    assign in_range  = |bar_sel;
    assign is_status = (word_idx == '0);

endmodule

// File: rtl/mbar_slot.sv
module mbar_slot #(
    parameter int unsigned NUM_CORES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [NUM_CORES-1:0]     wr_core_sel,
    input  logic                     wr_ok,
    input  logic [1:0]               wr_val,
    output logic [2*NUM_CORES-1:0]   flags_o,
    output logic                     release_o
);
    import mbar_pkg::*;

    typedef struct packed {
        logic [NUM_CORES-1:0][1:0] flag;
        logic                      rel;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic        all_passed;
    logic        all_present_q;

    always_comb begin
        all_passed    = 1'b1;
        all_present_q = 1'b1;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (st_q.flag[c] != FLAG_PASSED) all_passed    = 1'b0;
            if (st_q.flag[c] == FLAG_IDLE)   all_present_q = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (all_passed) begin
            // every core has gone through: re-arm the point
            st_d.flag = '0;
            st_d.rel  = 1'b0;
        end else begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (wr_en && wr_ok && wr_core_sel[c]) st_d.flag[c] = wr_val;
            end
            st_d.rel = 1'b1;
            for (int c = 0; c < NUM_CORES; c++) begin
                if (st_d.flag[c] == FLAG_IDLE) st_d.rel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o   = st_q.flag;
    assign release_o = st_q.rel;

    // R7
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_passed |=> (flags_o == '0 && !release_o));

    // R5
    release_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> all_present_q);

    // R6
    release_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && !all_passed) |=> release_o);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R3
        flag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.flag[c] != 2'd3);
    end

endmodule

// File: rtl/mbar_unit.sv
module mbar_unit #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_BARRIERS = 4,
    parameter int unsigned NUM_CORES    = 2   // 1 to 3, must fit the 4-word stride
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned FLAGS_W = 2 * NUM_CORES;

    typedef struct packed {
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;

    logic                    in_range;
    logic [NUM_BARRIERS-1:0] bar_sel;
    logic                    is_status;
    logic [NUM_CORES-1:0]    core_sel;
    logic                    wr_ok;
    logic [DATA_W-1:0]       rd_word;
    logic [FLAGS_W-1:0]      flags_w [NUM_BARRIERS];
    logic [NUM_BARRIERS-1:0] rel_w;

    mbar_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_BARRIERS(NUM_BARRIERS),
        .NUM_CORES   (NUM_CORES)
    ) decode_i (
        .addr     (req_addr),
        .in_range (in_range),
        .bar_sel  (bar_sel),
        .is_status(is_status),
        .core_sel (core_sel)
    );

    // only the two handshake codes are accepted into a flag
    assign wr_ok = (req_wdata == DATA_W'(1)) || (req_wdata == DATA_W'(2));

    for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_slot
        mbar_slot #(.NUM_CORES(NUM_CORES)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (req_valid && req_write && bar_sel[b]),
            .wr_core_sel(core_sel),
            .wr_ok      (wr_ok),
            .wr_val     (req_wdata[1:0]),
            .flags_o    (flags_w[b]),
            .release_o  (rel_w[b])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BARRIERS; b++) begin
            if (bar_sel[b]) begin
                if (is_status) rd_word = DATA_W'(rel_w[b]);
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (core_sel[c]) rd_word = DATA_W'(flags_w[b][2*c +: 2]);
                end
            end
        end
        rsp_d          = rsp_q;
        rsp_d.rd_valid = req_valid && !req_write;
        rsp_d.rd_data  = (req_valid && !req_write) ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rd_valid = rsp_q.rd_valid;
    assign rd_data  = rsp_q.rd_data;

    // R2
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R10
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !in_range) |=> (rd_data == '0));

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rd_valid && rd_data == '0));

endmodule

// File: tb/mbar_unit_tb.sv
`timescale 1ns/1ps
module mbar_unit_tb_top;

    localparam int NB = 4;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int mflag [NB][NC];
    bit mrel [NB];

    always #2 clk = ~clk;

    mbar_unit #(.ADDR_W(8), .DATA_W(32), .NUM_BARRIERS(NB), .NUM_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int b = int'(a) / 4;
        int w = int'(a) % 4;
        if (b >= NB) return 32'd0;
        if (w == 0) return {31'd0, mrel[b]};
        if (w - 1 < NC) return 32'(mflag[b][w-1]);
        return 32'd0;
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        int b = int'(a) / 4;
        int w = int'(a) % 4;
        if (b >= NB) return "R10";
        if (w == 0) return "R5";
        if (w - 1 < NC) return "R3";
        return "R9";
    endfunction

    task automatic model_step(input bit v, input bit wr, input logic [7:0] a, input logic [31:0] d);
        for (int b = 0; b < NB; b++) begin
            bit allp = 1;
            bit allin = 1;
            for (int c = 0; c < NC; c++) if (mflag[b][c] != 2) allp = 0;
            if (allp) begin
                for (int c = 0; c < NC; c++) mflag[b][c] = 0;
                mrel[b] = 0;
            end else begin
                if (v && wr && (int'(a) / 4 == b) && (int'(a) % 4 >= 1) &&
                    (int'(a) % 4 - 1 < NC) && (d == 1 || d == 2))
                    mflag[b][int'(a) % 4 - 1] = int'(d);
                for (int c = 0; c < NC; c++) if (mflag[b][c] == 0) allin = 0;
                mrel[b] = allin;
            end
        end
    endtask

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual valid/data=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp = model_read(a);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        model_step(1, wr, a, d);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        if (!wr) check(tag, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    task automatic idle();
        model_step(0, 0, 8'd0, 32'd0);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < NB; b++) begin
            mrel[b] = 0;
            for (int c = 0; c < NC; c++) mflag[b][c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state of every word
        for (int a = 0; a < 4 * NB; a++) do_op(0, 8'(a), 0, "R1");

        // Full handshake on point 1 (base 4); R2 layout and latency
        do_op(1, 8'd5, 1, "R3");
        do_op(0, 8'd5, 0, "R3");
        do_op(0, 8'd4, 0, "R5");          // one core still idle
        do_op(1, 8'd5, 0, "R4");          // zero ignored
        do_op(1, 8'd5, 3, "R4");
        do_op(1, 8'd5, 32'h101, "R4");
        do_op(0, 8'd5, 0, "R4");          // still 1
        do_op(1, 8'd4, 1, "R8");          // status write ignored
        do_op(0, 8'd4, 0, "R8");
        do_op(1, 8'd7, 1, "R9");
        do_op(0, 8'd7, 0, "R9");
        do_op(1, 8'd6, 1, "R3");
        do_op(0, 8'd4, 0, "R5");          // released next cycle
        do_op(0, 8'd0, 0, "R11");         // point 0 untouched
        do_op(1, 8'd5, 2, "R3");
        do_op(0, 8'd5, 0, "R3");
        do_op(0, 8'd4, 0, "R6");          // mixed: still released
        do_op(1, 8'd6, 2, "R6");
        do_op(1, 8'd5, 1, "R7");          // lands in re-arm cycle: dropped
        do_op(0, 8'd4, 0, "R7");
        do_op(0, 8'd5, 0, "R7");
        do_op(0, 8'd6, 0, "R7");

        // R10: out of range writes must not alias onto point 0
        do_op(1, 8'(4 * NB + 1), 1, "R10");
        do_op(1, 8'(4 * NB + 2), 1, "R10");
        do_op(1, 8'd129, 1, "R10");
        do_op(0, 8'(4 * NB + 1), 0, "R10");
        do_op(0, 8'd1, 0, "R10");
        do_op(0, 8'd0, 0, "R10");
        do_op(0, 8'd255, 0, "R10");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            int sel = int'($urandom % 16);
            logic [7:0] a;
            logic [31:0] d;
            if (sel == 0) a = 8'($urandom);
            else a = 8'($urandom % (4 * NB + 4));
            case ($urandom % 8)
                0: d = 0;
                1: d = 3;
                2: d = $urandom;
                3, 4, 5: d = 1;
                default: d = 2;
            endcase
            if ($urandom % 8 == 0) idle();
            else do_op(($urandom % 2) == 1, a, d, tag_for(a));
        end
        for (int a = 0; a < 4 * NB; a++) do_op(0, 8'(a), 0, "R11");

        summary();
    end

endmodule